// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block brings one clock domain out of power-on reset in a fixed order. An active-low external request puts the domain into reset before any functional clock runs. The block then turns the functional clock on, taking it from the crystal reference while the PLL is still unlocked, so that registers without reset can settle under a live clock. It waits a set number of reference cycles for the clock to be stable, and only then lets the reset go. The release passes through a two-stage synchronizer clocked by the functional clock.

When the PLL reports lock during the clock-on or stability phase, the functional clock moves from the crystal to the PLL. The move uses a break-before-make enable handshake, and the stability wait starts again from zero. A lock that arrives after release does not change the source. A new external request pulls the output reset low at once, with no clock edge needed, and restarts the whole sequence.

Top module: `porseq`

## Requirements
- R1: `func_rst_n` is active low. It goes low as soon as `ext_rst_n` goes low, with no clock edge needed, and it stays low while `ext_rst_n` is low.
- R2: While `ext_rst_n` is held low, `func_clk` has no rising edge from the third `xtal_clk` rising edge after the request onward.
- R3: With no PLL lock, and counting `xtal_clk` rising edges from the deassertion of `ext_rst_n`, `func_rst_n` is still low after edge 5+S and is high after edge 6+S. S is `STABLE_CYCLES` and the synchronizers have the default depth of 2.
- R4: Before any lock, the functional clock comes from the crystal. `func_clk` has exactly one rising edge per `xtal_clk` cycle once reset has been released.
- R5: A PLL lock is acted on at `xtal_clk` edge e = L+3, where L is the number of reference cycles from the deassertion of `ext_rst_n` to the lock. If e ≤ 4, the source becomes the PLL and the release time of R3 is kept. If 5 ≤ e ≤ 4+S, the source becomes the PLL and the stability count restarts, so the internal release comes at edge e+S. In both cases `func_rst_n` is low after edge R-1 and high after edge R+1, where R is the edge of internal release.
- R6: A lock that arrives after reset release has no effect. `func_clk` stays on the crystal and `func_rst_n` stays high.
- R7: While `xtal_clk` is stopped, deasserting `ext_rst_n` does not raise `func_rst_n` and does not start `func_clk`. The sequence completes once the clock resumes.
- R8: `func_rst_n` rises only on a rising edge of `func_clk`, one edge after the first synchronizer stage has gone high.
- R9: The two clock sources are never enabled together, and no extra pulses appear. While the PLL is selected, `func_clk` has as many rising edges as `pll_clk`.
- R10: The internal release happens only after a stability wait of S full cycles has completed. S must be at least 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtal_clk | input | 1 | Crystal reference clock; it runs the sequencer |
| pll_clk | input | 1 | PLL output clock |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| pll_locked | input | 1 | PLL lock indicator, asynchronous |
| func_clk | output | 1 | Selected, gated functional clock |
| func_rst_n | output | 1 | Functional reset, asserted asynchronously, released synchronously to `func_clk` |

## Verification
The bench counts reference clock edges from each reset deassertion. It samples on the falling edge of `xtal_clk`, where no design register changes. The internal release is due at edge 4+S, or S edges after a lock that is acted on at edge L+3. On the crystal path, `func_rst_n` follows two reference edges after the internal release, so the bench checks low after edge 5+S and high after edge 6+S. On the PLL path, the two synchronizer edges fall within one reference cycle, so the bench checks low one edge before the internal release and high one edge after it. The lock offset is swept across every cycle of the wait window and beyond it, and the clock source is then confirmed by counting `func_clk` edges over ten reference cycles.

// File: rtl/porseq_pkg.sv
`timescale 1ns/100ps
// Shared types for the power-on reset release sequencer.
package porseq_pkg;

    // Sequencer phases, in the order the power-on flow walks them.
    typedef enum logic [1:0] {
        PS_ASSERT   = 2'd0,
        PS_CLK_ON   = 2'd1,
        PS_WAIT     = 2'd2,
        PS_RELEASED = 2'd3
    } ps_state_t;

endpackage

// File: rtl/porseq_rstsync.sv
`timescale 1ns/100ps
// Reset synchronizer: asserts asynchronously and releases synchronously.
// Every stage clears at once when arst_n is low. A constant one then walks
// through STAGES flops on clk, so the output can only rise on a clk edge
// and cannot change while clk is stopped.
// Assumes STAGES >= 2.
module porseq_rstsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_out_n
);

    logic [STAGES-1:0] q;

    // Shift a one through the chain; clear every stage asynchronously.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q <= '0;
        end else begin
            q <= {q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_out_n = q[STAGES-1];

    // R8: the last stage may only rise after the stage before it was high.
    assert_two_stage_release_R8: assert property (
        @(posedge clk) disable iff (!arst_n)
        $rose(q[STAGES-1]) |-> $past(q[STAGES-2])
    );

endmodule

// File: rtl/porseq_clkswitch.sv
`timescale 1ns/100ps
// Glitch-free two-source clock switch with a run gate.
// Each source has an enable chain of two flops: the first samples on the
// rising edge, the second on the falling edge of that source's own clock.
// A source is enabled only after the other source's final enable is seen
// low, so the switch breaks before it makes. With run low, both enables
// drop and the output stays low.
// Assumes rst_n is synchronous to xtal_clk and held for at least one edge
// of both clocks.
module porseq_clkswitch (
    input  logic xtal_clk,
    input  logic pll_clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_pll,
    output logic clk_out
);

    logic x_a, x_b;
    logic p_a, p_b;

    // Crystal request stage: wanted, and PLL path fully off.
    always_ff @(posedge xtal_clk) begin
        if (!rst_n) x_a <= 1'b0;
        else        x_a <= run & ~use_pll & ~p_b;
    end

    // Crystal enable changes only while the crystal clock is low.
    always_ff @(negedge xtal_clk) begin
        if (!rst_n) x_b <= 1'b0;
        else        x_b <= x_a;
    end

    // PLL request stage: wanted, and crystal path fully off.
    always_ff @(posedge pll_clk) begin
        if (!rst_n) p_a <= 1'b0;
        else        p_a <= run & use_pll & ~x_b;
    end

    // PLL enable changes only while the PLL clock is low.
    always_ff @(negedge pll_clk) begin
        if (!rst_n) p_b <= 1'b0;
        else        p_b <= p_a;
    end

    assign clk_out = (xtal_clk & x_b) | (pll_clk & p_b);

    // R9: the two sources are never gated onto the output together.
    assert_one_source_R9: assert property (
        @(posedge xtal_clk) disable iff (!rst_n)
        !(x_b && p_b)
    );

endmodule

// File: rtl/porseq_fsm.sv
`timescale 1ns/100ps
// Power-on sequencing state machine, clocked by the crystal reference.
// Order: hold reset with the clock off, turn the clock on, wait
// STABLE_CYCLES for stability, then release. A lock seen while the clock
// is on but reset is not yet released selects the PLL and restarts the
// wait. Lock after release is ignored.
// Assumes seq_rst_n is a synchronous, active-low reset in this domain and
// that lock_sync is already synchronized.
module porseq_fsm
    import porseq_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic xtal_clk,
    input  logic seq_rst_n,
    input  logic lock_sync,
    output logic clk_run,
    output logic use_pll,
    output logic release_q
);

    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    ps_state_t      state, nxt;
    logic [CW-1:0]  cnt, cnt_n;
    logic           sel_q, sel_n;
    logic           run_q;
    logic           rel_q;

    // Next phase, wait counter and source choice.
    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        sel_n = sel_q;
        case (state)
            PS_ASSERT: nxt = PS_CLK_ON;
            PS_CLK_ON: begin
                nxt   = PS_WAIT;
                cnt_n = '0;
                if (lock_sync) sel_n = 1'b1;
            end
            PS_WAIT: begin
                if (lock_sync && !sel_q) begin
                    sel_n = 1'b1;
                    cnt_n = '0;
                end else if (cnt == LAST) begin
                    nxt = PS_RELEASED;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            PS_RELEASED: nxt = PS_RELEASED;
            default:     nxt = PS_ASSERT;
        endcase
    end

    // Phase registers with synchronous reset back to the asserted phase.
    always_ff @(posedge xtal_clk) begin
        if (!seq_rst_n) begin
            state <= PS_ASSERT;
            cnt   <= '0;
            sel_q <= 1'b0;
            run_q <= 1'b0;
            rel_q <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
            sel_q <= sel_n;
            run_q <= (nxt != PS_ASSERT);
            rel_q <= (nxt == PS_RELEASED);
        end
    end

    assign clk_run   = run_q;
    assign use_pll   = sel_q;
    assign release_q = rel_q;

    // R10: release only right after the last cycle of the wait.
    assert_release_after_wait_R10: assert property (
        @(posedge xtal_clk) disable iff (!seq_rst_n)
        $rose(rel_q) |-> ($past(state) == PS_WAIT && $past(cnt) == LAST)
    );

    // R10: the wait counter never passes its terminal value.
    assert_cnt_bound_R10: assert property (
        @(posedge xtal_clk) disable iff (!seq_rst_n)
        cnt <= LAST
    );

    // R5: taking the PLL always restarts the stability wait.
    assert_restart_on_lock_R5: assert property (
        @(posedge xtal_clk) disable iff (!seq_rst_n)
        $rose(sel_q) |-> (cnt == '0 && !rel_q)
    );

endmodule

// File: rtl/porseq.sv
`timescale 1ns/100ps
// Power-on reset release sequencer, top level.
// The external request is brought into the crystal domain with an
// assert-at-once synchronizer. The sequencer then drives the clock switch
// and the release. The functional reset clears at once on a request and
// is released through a synchronizer on the functional clock.
// Assumes the crystal runs whenever a release is expected, and that lock
// does not drop once the PLL is selected.
module porseq #(
    parameter int STABLE_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic xtal_clk,
    input  logic pll_clk,
    input  logic ext_rst_n,
    input  logic pll_locked,
    output logic func_clk,
    output logic func_rst_n
);

    logic                   seq_rst_n;
    logic [SYNC_STAGES-1:0] lock_q;
    logic                   clk_run;
    logic                   use_pll;
    logic                   release_q;
    logic                   int_rst_n;

    generate
        if (STABLE_CYCLES < 4 || SYNC_STAGES < 2) begin : g_bad_cfg
            initial $error("porseq: STABLE_CYCLES must be >= 4 and SYNC_STAGES >= 2");
        end
    endgenerate

    // Request synchronizer: sequencer reset follows ext_rst_n low at once.
    porseq_rstsync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk       (xtal_clk),
        .arst_n    (ext_rst_n),
        .rst_out_n (seq_rst_n)
    );

    // Lock synchronizer into the crystal domain (no reset: pure sampler).
    always_ff @(posedge xtal_clk) begin
        lock_q <= {lock_q[SYNC_STAGES-2:0], pll_locked};
    end

    porseq_fsm #(.STABLE_CYCLES(STABLE_CYCLES)) u_fsm (
        .xtal_clk  (xtal_clk),
        .seq_rst_n (seq_rst_n),
        .lock_sync (lock_q[SYNC_STAGES-1]),
        .clk_run   (clk_run),
        .use_pll   (use_pll),
        .release_q (release_q)
    );

    porseq_clkswitch u_clksw (
        .xtal_clk (xtal_clk),
        .pll_clk  (pll_clk),
        .rst_n    (seq_rst_n),
        .run      (clk_run),
        .use_pll  (use_pll),
        .clk_out  (func_clk)
    );

    // Internal reset: the external request or a sequence not yet released.
    assign int_rst_n = ext_rst_n & release_q;

    porseq_rstsync #(.STAGES(SYNC_STAGES)) u_out_sync (
        .clk       (func_clk),
        .arst_n    (int_rst_n),
        .rst_out_n (func_rst_n)
    );

endmodule

// File: tb/porseq_test.sv
`timescale 1ns/100ps
module porseq_test;

    localparam int S = 16;

    logic xtal_clk   = 1'b0;
    logic pll_clk    = 1'b0;
    logic ext_rst_n  = 1'b1;
    logic pll_locked = 1'b0;
    logic func_clk;
    logic func_rst_n;
    bit   xtal_run   = 1'b1;

    int checks   = 0;
    int failures = 0;
    int fe       = 0;
    int pe       = 0;

    porseq #(.STABLE_CYCLES(S)) uut (
        .xtal_clk   (xtal_clk),
        .pll_clk    (pll_clk),
        .ext_rst_n  (ext_rst_n),
        .pll_locked (pll_locked),
        .func_clk   (func_clk),
        .func_rst_n (func_rst_n)
    );

    // 100 MHz crystal, can be stopped; PLL at 3 ns, offset from crystal edges.
    always #5 if (xtal_run) xtal_clk = ~xtal_clk;
    initial begin
        #0.7;
        forever #1.5 pll_clk = ~pll_clk;
    end

    always @(posedge func_clk) fe++;
    always @(posedge pll_clk)  pe++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge xtal_clk);
    endtask

    // One power-on sequence; lock rises L cycles after deassert (0 = never).
    task automatic run_case(input int L);
        int  r;
        bit  pll;
        int  fe0;
        int  pe0;
        string tag;
        pll = (L >= 1 && L <= S + 1);
        r   = (L >= 2 && L <= S + 1) ? (L + 3 + S) : (4 + S);
        tag = pll ? "R5" : "R3";
        @(negedge xtal_clk);
        pll_locked = 1'b0;
        ext_rst_n  = 1'b0;
        step(1);
        chk("R1", "reset low during request", func_rst_n, 0);
        step(5);
        fe0 = fe;
        step(3);
        chk("R2", "func_clk quiet in reset", fe - fe0, 0);
        ext_rst_n = 1'b1;
        for (int n = 1; n <= r + 2; n++) begin
            @(negedge xtal_clk);
            if (n == r - 1)          chk(tag, "held before release", func_rst_n, 0);
            if (!pll && n == r + 1)  chk("R3", "crystal edge 5+S", func_rst_n, 0);
            if (pll && n == r + 1)   chk("R5", "pll release", func_rst_n, 1);
            if (n == r + 2)          chk(tag, "released", func_rst_n, 1);
            if (n == L)              pll_locked = 1'b1;
        end
        if (L > r + 2) pll_locked = 1'b1;
        step(2);
        fe0 = fe;
        pe0 = pe;
        step(10);
        if (pll) begin
            chk("R9", "func edges equal pll edges", fe - fe0, pe - pe0);
            chk("R5", "pll selected", int'((fe - fe0) >= 30), 1);
        end else if (L == 0) begin
            chk("R4", "crystal edges per 10 cycles", fe - fe0, 10);
        end else begin
            chk("R6", "late lock keeps crystal", fe - fe0, 10);
            chk("R6", "late lock keeps release", func_rst_n, 1);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        int fe0;
        #1 ext_rst_n = 1'b0;
        step(2);
        chk("R1", "reset state", func_rst_n, 0);

        run_case(0);
        for (int L = 1; L <= S + 4; L++) run_case(L);

        // R1: a request mid-cycle clears the output before any clock edge.
        @(negedge xtal_clk);
        #2 ext_rst_n = 1'b0;
        #1 chk("R1", "immediate assert", func_rst_n, 0);

        // R7: with the crystal stopped, deassert must not release.
        step(4);
        xtal_run = 1'b0;
        #20 ext_rst_n = 1'b1;
        fe0 = fe;
        #300;
        chk("R7", "no release without clock", func_rst_n, 0);
        chk("R7", "no func_clk without crystal", fe - fe0, 0);
        xtal_run = 1'b1;
        step(S + 8);
        chk("R7", "release after clock resumes", func_rst_n, 1);

        summary();
        $finish;
    end

    initial begin
        #1ms;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule